// File: doc/BRIEF.md
# Program Address Sequencer

This block produces the instruction fetch address for a small 4-bit controller. It holds a program counter, a last-in first-out return stack and a fixed-priority interrupt vector selector. In every cycle the instruction decoder presents one action code. The sequencer applies that action at the next clock edge: it steps the counter by one, steps it by two to skip, loads the jump operand, calls with a push, returns with a pop, loads the indirect address, accepts an interrupt, or holds.

Interrupt requests come in with an enable mask. When the decoder asks for an interrupt to be accepted, the enabled request with the lowest index wins. The sequencer returns a one-hot acknowledge in that same cycle, pushes the current counter as the resume point and jumps to that request's vector. A push on a full stack sets a sticky overflow flag. A pop on an empty stack sets a sticky underflow flag. Nothing wraps inside the stack.

Top module: `prog_sequencer`

## Requirements
- R1: After reset, fetch_addr_o is 0, ovf_o and unf_o are 0, and the stack is empty.
- R2: Action code 0 (step) sets the counter to its value plus one, modulo 2^ADDR_W. Action code 7 (hold) leaves the counter unchanged.
- R3: Action code 1 (skip) sets the counter to its value plus two, modulo 2^ADDR_W.
- R4: Action code 2 (jump) loads jump_addr_i into the counter.
- R5: Action code 3 (call) pushes the counter plus one onto the stack and loads jump_addr_i.
- R6: Action code 4 (return) pops the most recently pushed entry into the counter, in last-in first-out order.
- R7: Action code 5 (indirect) loads ind_addr_i into the counter.
- R8: Action code 6 (interrupt accept) works on the enabled requests, which are irq_req_i AND irq_mask_i. If any is enabled, the one at index k with the lowest index wins, so index 0 has the highest priority. The block then drives irq_ack_o to 1<<k in that same cycle, pushes the current counter value and loads the counter with k+1.
- R9: Action code 6 with no enabled request drives irq_ack_o to 0, sets the counter to its value plus one and pushes nothing.
- R10: A push while STACK_DEPTH entries are held stores nothing, still loads the new counter value, and sets ovf_o. The flag stays set until reset.
- R11: A return on an empty stack sets the counter to its value plus one, leaves the stack empty, and sets unf_o. The flag stays set until reset.
- R12: irq_ack_o is 0 whenever act_i is not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_i | input | 3 | Action code from the decoder |
| jump_addr_i | input | ADDR_W | Operand target for jump and call |
| ind_addr_i | input | ADDR_W | Indirect address source |
| irq_req_i | input | IRQ_N | Interrupt requests, index 0 highest priority |
| irq_mask_i | input | IRQ_N | Per-request enable, 1 = enabled |
| fetch_addr_o | output | ADDR_W | Current program counter / fetch address |
| irq_ack_o | output | IRQ_N | One-hot acknowledge of the accepted request |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The bench builds the block with its defaults: a 14-bit counter, an 8-deep stack and 4 requests. With 4 requests, all 256 combinations of request and mask can be tried. After each accept, a return is issued, so the priority choice, the vector, the acknowledge and the pushed resume address are all checked against a model the bench computes itself. With 8 entries, the stack can be filled to depth 9 and drained past empty within a short run, which reaches both sticky flags. Because the counter is 14 bits, the bench can jump to the top addresses and observe the wraparound of the step and skip actions.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [2:0] {
      ACT_INC  = 3'd0,
      ACT_SKIP = 3'd1,
      ACT_JUMP = 3'd2,
      ACT_CALL = 3'd3,
      ACT_RET  = 3'd4,
      ACT_IND  = 3'd5,
      ACT_IRQ  = 3'd6,
      ACT_HOLD = 3'd7
   } act_e;

endpackage

// File: rtl/seq_irq_pick.sv
module seq_irq_pick #(
   parameter int IRQ_N  = 4,
   parameter int ADDR_W = 14
) (
   input  logic [IRQ_N-1:0]  req_i,
   input  logic [IRQ_N-1:0]  mask_i,
   output logic [IRQ_N-1:0]  grant_o,
   output logic              any_o,
   output logic [ADDR_W-1:0] vec_o
);

   logic [IRQ_N-1:0] eff;
   logic [IRQ_N:0]   blocked;

   assign eff        = req_i & mask_i;
   assign blocked[0] = 1'b0;

   for (genvar g = 0; g < IRQ_N; g++) begin : g_prio
      assign grant_o[g]   = eff[g] & ~blocked[g];
      assign blocked[g+1] = blocked[g] | eff[g];
   end

   assign any_o = blocked[IRQ_N];

   always_comb begin
      vec_o = '0;
      for (int i = 0; i < IRQ_N; i++) begin
         if (grant_o[i]) vec_o = vec_o | ADDR_W'(i + 1);
      end
   end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_data_i,
   output logic [W-1:0] top_o,
   output logic         empty_o,
   output logic         ovf_o,
   output logic         unf_o
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic             full;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign empty_o = (cnt == '0);
   assign top_o   = empty_o ? '0 : mem[PTR_W'(cnt - CNT_W'(1))];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
      end else begin
         if (push_i) begin
            if (full) ovf_o <= 1'b1;
            else      cnt   <= cnt + CNT_W'(1);
         end else if (pop_i) begin
            if (empty_o) unf_o <= 1'b1;
            else         cnt   <= cnt - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !full) mem[PTR_W'(cnt)] <= push_data_i;
   end

endmodule

// File: rtl/seq_pc_next.sv
module seq_pc_next
   import seq_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  act_e              act_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] jump_i,
   input  logic [ADDR_W-1:0] ind_i,
   input  logic [ADDR_W-1:0] top_i,
   input  logic              stk_empty_i,
   input  logic              irq_any_i,
   input  logic [ADDR_W-1:0] irq_vec_i,
   output logic [ADDR_W-1:0] pc_nxt_o,
   output logic              push_o,
   output logic              pop_o,
   output logic [ADDR_W-1:0] push_data_o
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] pc_inc;
   assign pc_inc = pc_i + ONE;

   always_comb begin
      pc_nxt_o    = pc_inc;
      push_o      = 1'b0;
      pop_o       = 1'b0;
      push_data_o = pc_inc;
      unique case (act_i)
         ACT_INC:  pc_nxt_o = pc_inc;
         ACT_SKIP: pc_nxt_o = pc_i + TWO;
         ACT_JUMP: pc_nxt_o = jump_i;
         ACT_CALL: begin
            push_o   = 1'b1;
            pc_nxt_o = jump_i;
         end
         ACT_RET: begin
            pop_o = 1'b1;
            if (!stk_empty_i) pc_nxt_o = top_i;
         end
         ACT_IND:  pc_nxt_o = ind_i;
         ACT_IRQ: begin
            if (irq_any_i) begin
               push_o      = 1'b1;
               push_data_o = pc_i;
               pc_nxt_o    = irq_vec_i;
            end
         end
         ACT_HOLD: pc_nxt_o = pc_i;
         default:  pc_nxt_o = pc_inc;
      endcase
   end

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
   import seq_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int STACK_DEPTH = 8,
   parameter int IRQ_N       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        act_i,
   input  logic [ADDR_W-1:0] jump_addr_i,
   input  logic [ADDR_W-1:0] ind_addr_i,
   input  logic [IRQ_N-1:0]  irq_req_i,
   input  logic [IRQ_N-1:0]  irq_mask_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [IRQ_N-1:0]  irq_ack_o,
   output logic              ovf_o,
   output logic              unf_o
);

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("prog_sequencer: ADDR_W must lie in 4..32");
   end
   if (STACK_DEPTH < 2 || STACK_DEPTH > 256) begin : g_bad_depth
      $error("prog_sequencer: STACK_DEPTH must lie in 2..256");
   end
   if (IRQ_N < 1 || IRQ_N + 1 >= (1 << ADDR_W)) begin : g_bad_irq
      $error("prog_sequencer: IRQ_N vectors must fit the address space");
   end

   act_e              act;
   logic [ADDR_W-1:0] pc_q, pc_nxt, push_data, top, irq_vec;
   logic [IRQ_N-1:0]  grant;
   logic              irq_any, push, pop, stk_empty;

   assign act          = act_e'(act_i);
   assign fetch_addr_o = pc_q;
   assign irq_ack_o    = (act == ACT_IRQ) ? grant : '0;

   seq_irq_pick #(.IRQ_N(IRQ_N), .ADDR_W(ADDR_W)) u_pick (
      .req_i   (irq_req_i),
      .mask_i  (irq_mask_i),
      .grant_o (grant),
      .any_o   (irq_any),
      .vec_o   (irq_vec)
   );

   seq_pc_next #(.ADDR_W(ADDR_W)) u_next (
      .act_i       (act),
      .pc_i        (pc_q),
      .jump_i      (jump_addr_i),
      .ind_i       (ind_addr_i),
      .top_i       (top),
      .stk_empty_i (stk_empty),
      .irq_any_i   (irq_any),
      .irq_vec_i   (irq_vec),
      .pc_nxt_o    (pc_nxt),
      .push_o      (push),
      .pop_o       (pop),
      .push_data_o (push_data)
   );

   seq_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (push_data),
      .top_o       (top),
      .empty_o     (stk_empty),
      .ovf_o       (ovf_o),
      .unf_o       (unf_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_nxt;
   end

endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
   parameter int ADDR_W = 14,
   parameter int IRQ_N  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        act_i,
   input logic [ADDR_W-1:0] jump_addr_i,
   input logic [ADDR_W-1:0] ind_addr_i,
   input logic [IRQ_N-1:0]  irq_req_i,
   input logic [IRQ_N-1:0]  irq_mask_i,
   input logic [ADDR_W-1:0] fetch_addr_o,
   input logic [IRQ_N-1:0]  irq_ack_o,
   input logic              ovf_o,
   input logic              unf_o
);

   // R12
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i != 3'd6) |-> (irq_ack_o == '0));

   // R8
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack_o) && ((irq_ack_o & ~(irq_req_i & irq_mask_i)) == '0));

   // R3
   skip_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == 3'd1) |=> (fetch_addr_o == ADDR_W'($past(fetch_addr_o) + ADDR_W'(2))));

   // R4
   jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == 3'd2) |=> (fetch_addr_o == $past(jump_addr_i)));

   // R7
   ind_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == 3'd5) |=> (fetch_addr_o == $past(ind_addr_i)));

   // R2
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == 3'd7) |=> $stable(fetch_addr_o));

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   // R11
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |=> unf_o);

endmodule

bind prog_sequencer prog_sequencer_chk #(.ADDR_W(ADDR_W), .IRQ_N(IRQ_N)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .act_i        (act_i),
   .jump_addr_i  (jump_addr_i),
   .ind_addr_i   (ind_addr_i),
   .irq_req_i    (irq_req_i),
   .irq_mask_i   (irq_mask_i),
   .fetch_addr_o (fetch_addr_o),
   .irq_ack_o    (irq_ack_o),
   .ovf_o        (ovf_o),
   .unf_o        (unf_o)
);

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;

   localparam int AW = 14;
   localparam int SD = 8;
   localparam int IN = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    act = 3'd7;
   logic [AW-1:0] jmp = '0, ind = '0;
   logic [IN-1:0] req = '0, msk = '0;
   logic [AW-1:0] fetch;
   logic [IN-1:0] ack;
   logic          ovf, unf;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [AW-1:0] m_pc;
   logic [AW-1:0] m_stk [SD];
   int            m_cnt;
   logic          m_ovf, m_unf;

   always #4 clk = ~clk;

   prog_sequencer #(.ADDR_W(AW), .STACK_DEPTH(SD), .IRQ_N(IN)) u_dut (
      .clk(clk), .rst_n(rst_n), .act_i(act), .jump_addr_i(jmp),
      .ind_addr_i(ind), .irq_req_i(req), .irq_mask_i(msk),
      .fetch_addr_o(fetch), .irq_ack_o(ack), .ovf_o(ovf), .unf_o(unf)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R2 step";
         3'd1: return "R3 skip";
         3'd2: return "R4 jump";
         3'd3: return "R5 call";
         3'd4: return "R6 return";
         3'd5: return "R7 indirect";
         3'd6: return "R8 irq accept";
         default: return "R2 hold";
      endcase
   endfunction

   task automatic push_model(input logic [AW-1:0] v);
      if (m_cnt == SD) m_ovf = 1'b1;
      else begin m_stk[m_cnt] = v; m_cnt++; end
   endtask

   task automatic step(input logic [2:0] a, input logic [AW-1:0] j,
                       input logic [AW-1:0] i, input logic [IN-1:0] rq,
                       input logic [IN-1:0] mk);
      logic [IN-1:0] eff, exp_ack;
      int k;
      act = a; jmp = j; ind = i; req = rq; msk = mk;
      #1;
      eff = rq & mk; exp_ack = '0; k = -1;
      for (int n = IN - 1; n >= 0; n--) if (eff[n]) k = n;
      if (a == 3'd6 && k >= 0) exp_ack[k] = 1'b1;
      if (a != 3'd6)     chk("R12 ack idle", 32'(ack), 32'(exp_ack));
      else if (k < 0)    chk("R9 no pending ack", 32'(ack), 32'(exp_ack));
      else               chk("R8 ack priority", 32'(ack), 32'(exp_ack));
      case (a)
         3'd0: m_pc = m_pc + 1'b1;
         3'd1: m_pc = m_pc + 2'd2;
         3'd2: m_pc = j;
         3'd3: begin push_model(m_pc + 1'b1); m_pc = j; end
         3'd4: begin
            if (m_cnt == 0) begin m_unf = 1'b1; m_pc = m_pc + 1'b1; end
            else begin m_cnt--; m_pc = m_stk[m_cnt]; end
         end
         3'd5: m_pc = i;
         3'd6: begin
            if (k < 0) m_pc = m_pc + 1'b1;
            else begin push_model(m_pc); m_pc = AW'(k + 1); end
         end
         default: ;
      endcase
      @(negedge clk);
      if (a == 3'd6 && k < 0) chk("R9 no pending pc", 32'(fetch), 32'(m_pc));
      else                    chk(tag_of(a), 32'(fetch), 32'(m_pc));
      chk("R10 overflow flag", 32'(ovf), 32'(m_ovf));
      chk("R11 underflow flag", 32'(unf), 32'(m_unf));
   endtask

   task automatic do_reset();
      act = 3'd7; req = '0; msk = '0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_pc = '0; m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
      #1;
      chk("R1 reset pc", 32'(fetch), 32'h0);
      chk("R1 reset ovf", 32'(ovf), 32'h0);
      chk("R1 reset unf", 32'(unf), 32'h0);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1: empty stack after reset shows as underflow on first return
      step(3'd4, '0, '0, '0, '0);
      do_reset();
      for (int n = 0; n < 5; n++) step(3'd0, '0, '0, '0, '0);
      step(3'd7, '0, '0, '0, '0);
      step(3'd7, '0, '0, '0, '0);
      for (int n = 0; n < 3; n++) step(3'd1, '0, '0, '0, '0);
      for (int b = 0; b < AW; b++) step(3'd2, AW'(1 << b), '0, '0, '0);
      // R2 and R3 wraparound at the top of the address space
      step(3'd2, 14'h3FFF, '0, '0, '0);
      step(3'd0, '0, '0, '0, '0);
      step(3'd2, 14'h3FFE, '0, '0, '0);
      step(3'd1, '0, '0, '0, '0);
      step(3'd2, 14'h3FFF, '0, '0, '0);
      step(3'd1, '0, '0, '0, '0);
      for (int n = 0; n < 6; n++) step(3'd5, '0, AW'(n * 1111 + 7), '0, '0);
      // R8 R9 R12: every request/mask pairing, each followed by a return
      for (int r = 0; r < 16; r++) begin
         for (int m = 0; m < 16; m++) begin
            step(3'd2, AW'(16'h100 + (r * 16 + m) * 3), '0, '0, '0);
            step(3'd6, '0, '0, IN'(r), IN'(m));
            if ((r & m) != 0) step(3'd4, '0, '0, IN'(r), IN'(m));
            else              step(3'd0, '0, '0, IN'(r), IN'(m));
         end
      end
      // R5 R6 R10 R11: nested calls past full, returns past empty
      for (int n = 0; n < SD + 1; n++) step(3'd3, AW'(16'h200 + n * 16), '0, '0, '0);
      for (int n = 0; n < SD + 2; n++) step(3'd4, '0, '0, '0, '0);
      for (int n = 0; n < 3; n++) step(3'd0, '0, '0, '0, '0);
      do_reset();
      // R10: interrupt accept on a full stack
      for (int n = 0; n < SD; n++) step(3'd3, AW'(16'h400 + n), '0, '0, '0);
      step(3'd6, '0, '0, 4'b1000, 4'b1111);
      for (int n = 0; n < SD; n++) step(3'd4, '0, '0, '0, '0);
      do_reset();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule